// File: doc/BRIEF.md
# Prioritised interrupt CPU interface with split end-of-interrupt

This block collects a configurable number of interrupt sources (32 by default) and presents them to one processor as a single registered interrupt request line. Each source holds a pending bit, an active bit and an 8-bit priority, where a smaller number is more urgent. The processor drives a one-command-per-cycle valid/strobe port. With it, the processor acknowledges the winning source, ends handling, deactivates a source, or marks a source pending by software. A separate port writes the priorities.

The interface keeps a running priority. Only a source strictly more urgent than that running priority is signaled. Acknowledged priorities go onto a small stack, so interrupts can nest and each end-of-interrupt brings back the priority that was in force before.

A mode input selects how end-of-interrupt works. With the mode at 0, one end-of-interrupt command both lowers the running priority and clears the active bit. With the mode at 1, the end-of-interrupt command only lowers the running priority. The active bit then keeps that source masked until a separate deactivate command clears it, while other sources can already be signaled. A software handler can use this window to defer the rest of its work without touching any mask register.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, `irq_o` is 0, `ack_valid_o` is 0 and `running_prio_o` is 0xFF (idle).
- R2: An acknowledge command (`cmd_op_i`=0) makes `ack_valid_o` pulse high for exactly the next cycle, with `ack_id_o` holding the winning source. The winner is the eligible source with the numerically smallest priority; on a tie the lowest ID wins.
- R3: A successful acknowledge sets the winner's active bit, clears its pending bit and pushes its priority, so `running_prio_o` equals that priority from the next cycle on.
- R4: A source is eligible only when it is pending, not active, and its priority is strictly smaller than `running_prio_o`. Equal or larger values are held back, and a source with priority 0xFF is never signaled.
- R5: A source whose active bit is set is neither signaled nor acknowledged, even if it becomes pending again. It becomes eligible again once it is deactivated.
- R6: An acknowledge with no eligible source returns ID 1023 and leaves the running priority, pending bits and active bits unchanged.
- R7: With `split_mode_i`=0, an end-of-interrupt command (`cmd_op_i`=1) restores the previous running priority and clears the active bit of `cmd_id_i` in the same cycle.
- R8: With `split_mode_i`=1, an end-of-interrupt command only restores the previous running priority; the source stays active. A deactivate command (`cmd_op_i`=2) clears the active bit of `cmd_id_i` in either mode.
- R9: The stack of acknowledged priorities is 4 deep. Each end-of-interrupt pops one entry and restores the priority below it, or 0xFF when the stack becomes empty. An end-of-interrupt with an empty stack leaves the running priority at 0xFF.
- R10: While 4 priorities are on the stack, no source is signaled and an acknowledge returns 1023.
- R11: A set-pending command (`cmd_op_i`=3) or a rising edge on `src_i[n]` sets pending bit n. A source input held high produces no second event.
- R12: `irq_o` is registered: it reflects a state change one cycle after the clock edge that made that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Hardware interrupt sources, rising-edge sensitive |
| split_mode_i | input | 1 | 0: combined end-of-interrupt, 1: split drop and deactivate |
| prio_we_i | input | 1 | Priority write strobe |
| prio_id_i | input | 5 | Source whose priority is written |
| prio_data_i | input | 8 | New priority value (smaller is more urgent) |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 acknowledge, 1 end-of-interrupt, 2 deactivate, 3 set pending |
| cmd_id_i | input | 10 | Source ID for end-of-interrupt, deactivate and set pending |
| ack_valid_o | output | 1 | One-cycle pulse after an acknowledge command |
| ack_id_o | output | 10 | ID returned by the last acknowledge (1023 = spurious) |
| irq_o | output | 1 | Registered interrupt request to the processor |
| running_prio_o | output | 8 | Current running priority (0xFF when idle) |

## Verification
The bench targets the window between priority drop and deactivate in split mode. There it checks that a repended source stays silent and that another source is signaled. A design that cleared the active bit on the drop would raise the request too early. Ties of equal priority must go to the lower ID, and an equal-priority source must be held back behind a running one. A comparison using less-or-equal would signal in both cases.

The bench also drives the stack to full, to empty and past empty. A wrong stack pointer shows up as a wrong restored priority or as a source signaled while the stack is full. Finally, a level held on a source input must not re-trigger after handling, which a level-sensitive design would do.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;

   typedef enum logic [1:0] {
      OP_ACK     = 2'd0,
      OP_EOI     = 2'd1,
      OP_DEACT   = 2'd2,
      OP_SETPEND = 2'd3
   } irq_op_e;

   localparam int unsigned DEFAULT_NUM_SRC   = 32;
   localparam int unsigned DEFAULT_PRIO_W    = 8;
   localparam int unsigned DEFAULT_ID_W      = 10;
   localparam int unsigned DEFAULT_STACK_DEP = 4;

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] set_pend_i,
   input  logic [NUM_SRC-1:0] clr_pend_i,
   input  logic [NUM_SRC-1:0] set_act_i,
   input  logic [NUM_SRC-1:0] clr_act_i,
   output logic [NUM_SRC-1:0] pending_o,
   output logic [NUM_SRC-1:0] active_o
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
      logic src_q;
      logic pend_q;
      logic act_q;
      logic edge_seen;

      assign edge_seen = src_i[i] & ~src_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            src_q  <= 1'b0;
            pend_q <= 1'b0;
            act_q  <= 1'b0;
         end else begin
            src_q  <= src_i[i];
            pend_q <= (pend_q & ~clr_pend_i[i]) | set_pend_i[i] | edge_seen;
            act_q  <= (act_q | set_act_i[i]) & ~clr_act_i[i];
         end
      end

      assign pending_o[i] = pend_q;
      assign active_o[i]  = act_q;
   end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int unsigned NUM_SRC    = 32,
   parameter int unsigned PRIO_W     = 8,
   parameter logic [PRIO_W-1:0] PRIO_RESET = 8'h80,
   localparam int unsigned IDX_W     = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [IDX_W-1:0]   wid_i,
   input  logic [PRIO_W-1:0]  wdata_i,
   input  logic [NUM_SRC-1:0] pending_i,
   input  logic [NUM_SRC-1:0] active_i,
   input  logic [PRIO_W-1:0]  running_i,
   input  logic               block_i,
   output logic               win_valid_o,
   output logic [IDX_W-1:0]   win_id_o,
   output logic [PRIO_W-1:0]  win_prio_o
);

   logic [PRIO_W-1:0]  prio [NUM_SRC];
   logic [NUM_SRC-1:0] elig;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
      logic [PRIO_W-1:0] prio_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q <= PRIO_RESET;
         end else if (we_i && (wid_i == IDX_W'(i))) begin
            prio_q <= wdata_i;
         end
      end

      assign prio[i] = prio_q;
      assign elig[i] = pending_i[i] & ~active_i[i] & ~block_i &
                       (prio_q < running_i);
   end

   always_comb begin
      win_valid_o = 1'b0;
      win_id_o    = '0;
      win_prio_o  = '1;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (elig[i] && (!win_valid_o || (prio[i] < win_prio_o))) begin
            win_valid_o = 1'b1;
            win_id_o    = IDX_W'(i);
            win_prio_o  = prio[i];
         end
      end
   end

endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned PRIO_W = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [PRIO_W-1:0] push_prio_i,
   input  logic              pop_i,
   output logic [PRIO_W-1:0] top_o,
   output logic              full_o,
   output logic              empty_o
);

   logic [CNT_W-1:0]  cnt_q;
   logic [PRIO_W-1:0] entry [DEPTH];
   logic              do_push;
   logic              do_pop;

   assign full_o  = (cnt_q == CNT_W'(DEPTH));
   assign empty_o = (cnt_q == '0);
   assign do_push = push_i & ~full_o;
   assign do_pop  = pop_i & ~empty_o & ~push_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (do_push) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (do_pop) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   if (DEPTH == 1) begin : g_single
      logic [PRIO_W-1:0] slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '1;
         end else if (do_push) begin
            slot_q <= push_prio_i;
         end
      end
      assign entry[0] = slot_q;
   end else begin : g_multi
      for (genvar e = 0; e < DEPTH; e++) begin : g_slot
         logic [PRIO_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q <= '1;
            end else if (do_push && (cnt_q == CNT_W'(e))) begin
               slot_q <= push_prio_i;
            end
         end
         assign entry[e] = slot_q;
      end
   end

   always_comb begin
      top_o = '1;
      for (int e = 0; e < DEPTH; e++) begin
         if (cnt_q == CNT_W'(e + 1)) begin
            top_o = entry[e];
         end
      end
   end

endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
   import irq_cpu_pkg::*;
#(
   parameter int unsigned NUM_SRC     = DEFAULT_NUM_SRC,
   parameter int unsigned PRIO_W      = DEFAULT_PRIO_W,
   parameter int unsigned ID_W        = DEFAULT_ID_W,
   parameter int unsigned STACK_DEPTH = DEFAULT_STACK_DEP,
   parameter int unsigned SPURIOUS_ID = 1023,
   parameter logic [PRIO_W-1:0] PRIO_RESET = 8'h80,
   localparam int unsigned IDX_W      = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               split_mode_i,
   input  logic               prio_we_i,
   input  logic [IDX_W-1:0]   prio_id_i,
   input  logic [PRIO_W-1:0]  prio_data_i,
   input  logic               cmd_valid_i,
   input  logic [1:0]         cmd_op_i,
   input  logic [ID_W-1:0]    cmd_id_i,
   output logic               ack_valid_o,
   output logic [ID_W-1:0]    ack_id_o,
   output logic               irq_o,
   output logic [PRIO_W-1:0]  running_prio_o
);

   if (NUM_SRC < 2) begin : g_bad_src
      $error("irq_cpu_if: NUM_SRC must be at least 2");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("irq_cpu_if: STACK_DEPTH must be at least 1");
   end
   if ((SPURIOUS_ID < NUM_SRC) || (SPURIOUS_ID >= (2 ** ID_W))) begin : g_bad_spur
      $error("irq_cpu_if: SPURIOUS_ID must lie above the sources and fit ID_W");
   end
   if (PRIO_W < 2) begin : g_bad_prio
      $error("irq_cpu_if: PRIO_W must be at least 2");
   end

   irq_op_e            op;
   logic               id_ok;
   logic [NUM_SRC-1:0] cmd_oh;
   logic               ack_cmd;
   logic               ack_hit;
   logic               eoi_cmd;
   logic               deact_hit;
   logic               setpend_hit;

   logic [NUM_SRC-1:0] pending_q;
   logic [NUM_SRC-1:0] active_q;
   logic [NUM_SRC-1:0] win_oh;
   logic [NUM_SRC-1:0] set_pend;
   logic [NUM_SRC-1:0] clr_pend;
   logic [NUM_SRC-1:0] set_act;
   logic [NUM_SRC-1:0] clr_act;

   logic               win_valid;
   logic [IDX_W-1:0]   win_id;
   logic [PRIO_W-1:0]  win_prio;
   logic [PRIO_W-1:0]  stack_top;
   logic               stack_full;
   logic               stack_empty;

   assign op          = irq_op_e'(cmd_op_i);
   assign id_ok       = (cmd_id_i < ID_W'(NUM_SRC));
   assign cmd_oh      = id_ok ? (NUM_SRC'(1) << cmd_id_i[IDX_W-1:0]) : '0;
   assign ack_cmd     = cmd_valid_i && (op == OP_ACK);
   assign ack_hit     = ack_cmd && win_valid;
   assign eoi_cmd     = cmd_valid_i && (op == OP_EOI);
   assign deact_hit   = cmd_valid_i &&
                        ((op == OP_DEACT) || ((op == OP_EOI) && !split_mode_i));
   assign setpend_hit = cmd_valid_i && (op == OP_SETPEND);

   assign win_oh   = NUM_SRC'(1) << win_id;
   assign set_pend = setpend_hit ? cmd_oh : '0;
   assign clr_pend = ack_hit ? win_oh : '0;
   assign set_act  = ack_hit ? win_oh : '0;
   assign clr_act  = deact_hit ? cmd_oh : '0;

   irq_src_bank #(
      .NUM_SRC (NUM_SRC)
   ) i_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_i),
      .set_pend_i (set_pend),
      .clr_pend_i (clr_pend),
      .set_act_i  (set_act),
      .clr_act_i  (clr_act),
      .pending_o  (pending_q),
      .active_o   (active_q)
   );

   irq_prio_sel #(
      .NUM_SRC    (NUM_SRC),
      .PRIO_W     (PRIO_W),
      .PRIO_RESET (PRIO_RESET)
   ) i_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_i        (prio_we_i),
      .wid_i       (prio_id_i),
      .wdata_i     (prio_data_i),
      .pending_i   (pending_q),
      .active_i    (active_q),
      .running_i   (stack_top),
      .block_i     (stack_full),
      .win_valid_o (win_valid),
      .win_id_o    (win_id),
      .win_prio_o  (win_prio)
   );

   irq_prio_stack #(
      .DEPTH  (STACK_DEPTH),
      .PRIO_W (PRIO_W)
   ) i_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (ack_hit),
      .push_prio_i (win_prio),
      .pop_i       (eoi_cmd),
      .top_o       (stack_top),
      .full_o      (stack_full),
      .empty_o     (stack_empty)
   );

   assign running_prio_o = stack_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_valid_o <= 1'b0;
         ack_id_o    <= ID_W'(SPURIOUS_ID);
         irq_o       <= 1'b0;
      end else begin
         ack_valid_o <= ack_cmd;
         irq_o       <= win_valid;
         if (ack_cmd) begin
            ack_id_o <= ack_hit ? ID_W'(win_id) : ID_W'(SPURIOUS_ID);
         end
      end
   end

endmodule

// File: rtl/irq_cpu_chk.sv
module irq_cpu_chk #(
   parameter int unsigned NUM_SRC     = 32,
   parameter int unsigned PRIO_W      = 8,
   parameter int unsigned ID_W        = 10,
   parameter int unsigned SPURIOUS_ID = 1023,
   localparam int unsigned IDX_W      = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid_i,
   input logic [1:0]         cmd_op_i,
   input logic [ID_W-1:0]    cmd_id_i,
   input logic               split_mode_i,
   input logic               ack_valid_o,
   input logic [ID_W-1:0]    ack_id_o,
   input logic               irq_o,
   input logic [PRIO_W-1:0]  running_prio_o,
   input logic [NUM_SRC-1:0] active_q,
   input logic               win_valid,
   input logic               stack_full
);

   logic               is_ack;
   logic               is_eoi;
   logic [NUM_SRC-1:0] cmd_oh;
   logic [NUM_SRC-1:0] ack_oh;
   logic               ack_real;

   assign is_ack   = cmd_valid_i && (cmd_op_i == 2'd0);
   assign is_eoi   = cmd_valid_i && (cmd_op_i == 2'd1);
   assign cmd_oh   = (cmd_id_i < ID_W'(NUM_SRC)) ? (NUM_SRC'(1) << cmd_id_i[IDX_W-1:0]) : '0;
   assign ack_oh   = NUM_SRC'(1) << ack_id_o[IDX_W-1:0];
   assign ack_real = ack_valid_o && (ack_id_o != ID_W'(SPURIOUS_ID));

   // R2
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_ack |=> ack_valid_o);

   // R2
   ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid_o |-> $past(is_ack));

   // R3
   ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_ack |=> (ack_id_o == ID_W'(SPURIOUS_ID)) || (running_prio_o < $past(running_prio_o)));

   // R5
   ack_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_real |-> (($past(active_q) & ack_oh) == '0));

   // R6
   spur_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ack && !win_valid) |=> ((ack_id_o == ID_W'(SPURIOUS_ID)) &&
                                  $stable(running_prio_o) && $stable(active_q)));

   // R7
   eoi_deact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_eoi && !split_mode_i) |=> ((active_q & $past(cmd_oh)) == '0));

   // R8
   split_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_eoi && split_mode_i) |=> ((active_q & $past(cmd_oh)) == ($past(active_q) & $past(cmd_oh))));

   // R9
   empty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_eoi && (running_prio_o == '1)) |=> (running_prio_o == '1));

   // R10
   full_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stack_full |=> !irq_o);

   // R12
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(win_valid));

endmodule

bind irq_cpu_if irq_cpu_chk #(
   .NUM_SRC     (NUM_SRC),
   .PRIO_W      (PRIO_W),
   .ID_W        (ID_W),
   .SPURIOUS_ID (SPURIOUS_ID)
) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_valid_i    (cmd_valid_i),
   .cmd_op_i       (cmd_op_i),
   .cmd_id_i       (cmd_id_i),
   .split_mode_i   (split_mode_i),
   .ack_valid_o    (ack_valid_o),
   .ack_id_o       (ack_id_o),
   .irq_o          (irq_o),
   .running_prio_o (running_prio_o),
   .active_q       (active_q),
   .win_valid      (win_valid),
   .stack_full     (stack_full)
);

// File: tb/test_irq_cpu_if.sv
`timescale 1ns/1ps
module test_irq_cpu_if;

   localparam int N = 32;
   localparam logic [9:0] SPUR = 10'd1023;
   localparam logic [1:0] A = 2'd0, E = 2'd1, D = 2'd2, S = 2'd3;

   // {op, mode, id, exp_ack, exp_rp, exp_irq}
   localparam int NV = 22;
   localparam logic [31:0] VEC [NV] = '{
      {S, 1'b0, 10'd5,  10'd0,  8'hFF, 1'b1},
      {S, 1'b0, 10'd3,  10'd0,  8'hFF, 1'b1},
      {A, 1'b0, 10'd0,  10'd3,  8'h40, 1'b0},
      {S, 1'b0, 10'd7,  10'd0,  8'h40, 1'b1},
      {A, 1'b0, 10'd0,  10'd7,  8'h20, 1'b0},
      {A, 1'b0, 10'd0,  SPUR,   8'h20, 1'b0},
      {E, 1'b0, 10'd7,  10'd0,  8'h40, 1'b0},
      {E, 1'b0, 10'd3,  10'd0,  8'hFF, 1'b1},
      {A, 1'b0, 10'd0,  10'd5,  8'h40, 1'b0},
      {S, 1'b1, 10'd5,  10'd0,  8'h40, 1'b0},
      {E, 1'b1, 10'd5,  10'd0,  8'hFF, 1'b0},
      {A, 1'b1, 10'd0,  SPUR,   8'hFF, 1'b0},
      {S, 1'b1, 10'd10, 10'd0,  8'hFF, 1'b1},
      {A, 1'b1, 10'd0,  10'd10, 8'h60, 1'b0},
      {E, 1'b1, 10'd10, 10'd0,  8'hFF, 1'b0},
      {D, 1'b1, 10'd5,  10'd0,  8'hFF, 1'b1},
      {A, 1'b1, 10'd0,  10'd5,  8'h40, 1'b0},
      {E, 1'b1, 10'd5,  10'd0,  8'hFF, 1'b0},
      {D, 1'b1, 10'd5,  10'd0,  8'hFF, 1'b0},
      {D, 1'b1, 10'd10, 10'd0,  8'hFF, 1'b0},
      {E, 1'b1, 10'd0,  10'd0,  8'hFF, 1'b0},
      {A, 1'b0, 10'd0,  SPUR,   8'hFF, 1'b0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src_i = '0;
   logic         split_mode_i = 1'b0;
   logic         prio_we_i = 1'b0;
   logic [4:0]   prio_id_i = '0;
   logic [7:0]   prio_data_i = '0;
   logic         cmd_valid_i = 1'b0;
   logic [1:0]   cmd_op_i = '0;
   logic [9:0]   cmd_id_i = '0;
   logic         ack_valid_o;
   logic [9:0]   ack_id_o;
   logic         irq_o;
   logic [7:0]   running_prio_o;

   int checks = 0;
   int errors = 0;
   logic       s_ackv;
   logic [9:0] s_ack;
   logic [7:0] s_rp;
   logic       s_irq;

   always #2 clk = ~clk;

   irq_cpu_if i_irq_cpu_if (
      .clk            (clk),
      .rst_n          (rst_n),
      .src_i          (src_i),
      .split_mode_i   (split_mode_i),
      .prio_we_i      (prio_we_i),
      .prio_id_i      (prio_id_i),
      .prio_data_i    (prio_data_i),
      .cmd_valid_i    (cmd_valid_i),
      .cmd_op_i       (cmd_op_i),
      .cmd_id_i       (cmd_id_i),
      .ack_valid_o    (ack_valid_o),
      .ack_id_o       (ack_id_o),
      .irq_o          (irq_o),
      .running_prio_o (running_prio_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_prio(input int id, input logic [7:0] p);
      @(negedge clk);
      prio_we_i = 1'b1; prio_id_i = 5'(id); prio_data_i = p;
      @(negedge clk);
      prio_we_i = 1'b0;
   endtask

   // drive one command, sample ack/rp one cycle later, irq one more cycle later
   task automatic cmd(input logic [1:0] op, input logic mode, input int id);
      @(negedge clk);
      cmd_valid_i = 1'b1; cmd_op_i = op; cmd_id_i = 10'(id); split_mode_i = mode;
      @(negedge clk);
      cmd_valid_i = 1'b0;
      s_ackv = ack_valid_o; s_ack = ack_id_o; s_rp = running_prio_o;
      @(negedge clk);
      s_irq = irq_o;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 irq", int'(irq_o), 0);
      check("R1 ack_valid", int'(ack_valid_o), 0);
      check("R1 rp", int'(running_prio_o), 'hFF);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 irq after release", int'(irq_o), 0);

      set_prio(3, 8'h40);
      set_prio(5, 8'h40);
      set_prio(7, 8'h20);
      set_prio(10, 8'h60);

      // vector table: R2 R3 R4 R5 R6 R7 R8 R9 R11
      for (int v = 0; v < NV; v++) begin
         cmd(VEC[v][31:30], VEC[v][29], int'(VEC[v][28:19]));
         check($sformatf("R9 R7 R8 rp vec%0d", v), int'(s_rp), int'(VEC[v][8:1]));
         check($sformatf("R4 R5 R11 irq vec%0d", v), int'(s_irq), int'(VEC[v][0]));
         if (VEC[v][31:30] == A) begin
            check($sformatf("R2 R6 ack id vec%0d", v), int'(s_ack), int'(VEC[v][18:9]));
            check($sformatf("R2 ack_valid vec%0d", v), int'(s_ackv), 1);
         end else begin
            check($sformatf("R2 no ack_valid vec%0d", v), int'(s_ackv), 0);
         end
      end

      // R10 stack full with four nested levels
      set_prio(20, 8'h70);
      set_prio(21, 8'h60);
      set_prio(22, 8'h50);
      set_prio(23, 8'h30);
      set_prio(24, 8'h10);
      for (int k = 0; k < 4; k++) begin
         cmd(S, 1'b0, 20 + k);
         cmd(A, 1'b0, 0);
         check("R3 nested ack id", int'(s_ack), 20 + k);
      end
      check("R3 nested rp", int'(s_rp), 'h30);
      cmd(S, 1'b0, 24);
      check("R10 irq held while full", int'(s_irq), 0);
      cmd(A, 1'b0, 0);
      check("R10 ack spurious while full", int'(s_ack), 1023);
      check("R10 rp unchanged", int'(s_rp), 'h30);
      cmd(E, 1'b0, 23);
      check("R9 rp after pop", int'(s_rp), 'h50);
      check("R10 irq once room", int'(s_irq), 1);
      cmd(A, 1'b0, 0);
      check("R2 ack after room", int'(s_ack), 24);
      check("R3 rp most urgent", int'(s_rp), 'h10);
      cmd(E, 1'b0, 24);
      check("R9 rp restore 50", int'(s_rp), 'h50);
      cmd(E, 1'b0, 22);
      check("R9 rp restore 60", int'(s_rp), 'h60);
      cmd(E, 1'b0, 21);
      check("R9 rp restore 70", int'(s_rp), 'h70);
      cmd(E, 1'b0, 20);
      check("R9 rp back to idle", int'(s_rp), 'hFF);

      // R11 R12 hardware edge and registered request
      @(negedge clk);
      src_i[12] = 1'b1;
      @(negedge clk);
      check("R12 irq not yet", int'(irq_o), 0);
      @(negedge clk);
      check("R11 R12 irq after edge", int'(irq_o), 1);
      cmd(A, 1'b0, 0);
      check("R11 ack edge source", int'(s_ack), 12);
      cmd(E, 1'b0, 12);
      check("R11 held level no retrigger", int'(s_irq), 0);
      cmd(A, 1'b0, 0);
      check("R11 held level spurious", int'(s_ack), 1023);
      @(negedge clk);
      src_i[12] = 1'b0;
      @(negedge clk);
      src_i[12] = 1'b1;
      repeat (2) @(negedge clk);
      check("R11 new edge retriggers", int'(irq_o), 1);
      cmd(A, 1'b0, 0);
      check("R11 ack new edge", int'(s_ack), 12);
      cmd(E, 1'b0, 12);

      // R4 priority 0xFF never signaled
      set_prio(13, 8'hFF);
      cmd(S, 1'b0, 13);
      check("R4 prio FF irq", int'(s_irq), 0);
      cmd(A, 1'b0, 0);
      check("R4 prio FF spurious", int'(s_ack), 1023);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule